// File: doc/BRIEF.md
# Audio Receiver Status and Interrupt Controller

This block holds the event status byte and its interrupt mask for a digital audio interface receiver. The receive datapath feeds it single-cycle strobes (block end, block-boundary violation, channel-status bit pairs, channel-status byte writes, sample slip) and a few level signals (second-level error sources with their enables, buffer position flags). It folds them into one 8-bit status byte, raises an active-low interrupt pulse the first time an enabled condition appears, and drives an error-flag output.

The two top bits change meaning with the buffer mode. In the single-channel modes (0 and 1) bit 6 reports a CRC error on the channel picked by `ch_sel` and bit 7 reports a left/right channel-status mismatch. In the dual-channel modes (2, and 3 treated as 2) bit 6 and bit 7 report CRC errors on channel 1 and channel 2. Channel-status change detection keeps the first bytes of each channel from the previous block and compares every new write against them.

Software reaches the block through a small register port. A read at the status address returns the status byte and clears the latched event bits. A write at the same address loads the interrupt-enable byte.

Top module: `audio_rx_irq_ctrl`

## Requirements
- R1: After reset, the enable byte is 0, all latched bits are 0, `irq_n` is 1, `err_flag` is 0, and a status read returns 0x00 while all level inputs are low.
- R2: Status byte layout: bit 7 mismatch/CRC2, bit 6 CRC/CRC1, bit 5 channel-status change, bit 4 slip, bit 3 error flag, bits 2..0 are `pos_flags[2:0]` as registered one clock earlier.
- R3: In modes 0 and 1, bit 6 sets only when `blk_end` is high, from `crc_err[0]` (channel 1) when `ch_sel`=0 or `crc_err[1]` (channel 2) when `ch_sel`=1. The other channel's error and any `crc_err` level without `blk_end` have no effect.
- R4: In modes 2 and 3, `blk_end` sets bit 6 from `crc_err[0]` and bit 7 from `crc_err[1]`.
- R5: `blk_viol` sets bit 6 in every mode, and also bit 7 in modes 2 and 3.
- R6: In modes 0 and 1, a `pair_vld` strobe with `pair_bits[0]` != `pair_bits[1]` sets bit 7. In modes 2 and 3 the bit pair has no effect.
- R7: A `cs_wr` of byte index 0..3 sets bit 5 when the same channel (`cs_ch` 0 = channel 1) and index already hold a byte that differs from the new one. The first write to a slot after reset never sets it, index 4 and above is never compared, and in modes 0 and 1 only the channel equal to `ch_sel` counts. The stored byte is updated on every write.
- R8: `slip_evt` sets bit 4 only while `slave_mode` is 1.
- R9: Bit 3 and `err_flag` equal the OR of `err_src & err_en`, registered one clock.
- R10: A read at address 0 puts the status byte on `bus_rdata` one clock later and clears bits 7..4. An event arriving in the same clock as the read is kept for the next read. Bits 3..0 are not cleared.
- R11: A write at address 0 loads the enable byte, bit n unmasking status bit n. Writes at other addresses are ignored. Reads at other addresses return 0x00 and clear nothing.
- R12: `irq_n` is low for one clock, one clock after an event on an enabled bit, if that bit has not already been seen since the last status read. Level bits 3..0 raise an event on a 0-to-1 change. Masked events latch without an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_mode | input | 2 | Buffer mode; 0,1 single channel, 2,3 dual channel |
| ch_sel | input | 1 | Buffered channel in single modes (0 = channel 1) |
| slave_mode | input | 1 | Audio serial port takes frame sync and bit clock as inputs |
| blk_end | input | 1 | Block boundary strobe |
| blk_viol | input | 1 | Block boundary violation strobe |
| crc_err | input | 2 | CRC error of the closing block, [0] channel 1, [1] channel 2 |
| pair_vld | input | 1 | Channel-status bit pair strobe |
| pair_bits | input | 2 | Channel-status bit of channel 1 [0] and channel 2 [1] |
| cs_wr | input | 1 | Channel-status byte written to buffer |
| cs_ch | input | 1 | Channel of written byte (0 = channel 1) |
| cs_idx | input | 5 | Index of written byte |
| cs_byte | input | 8 | Value of written byte |
| slip_evt | input | 1 | Output sample dropped or repeated |
| err_src | input | 5 | Second-level error sources |
| err_en | input | 5 | Enables for the second-level error sources |
| pos_flags | input | 3 | Buffer position flags, [2] first CS bytes, [0] last user bytes |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after `bus_rd` |
| irq_n | output | 1 | Active-low interrupt pulse |
| err_flag | output | 1 | Registered error flag |

## Verification
CRC strobes are applied with the error on the selected channel, on the other channel and without a block end, in both mode groups, which tells the mode-dependent meaning of bits 6 and 7 apart from plain latching. Channel-status writes cover a first write, an equal rewrite, a changed byte, a change on the unselected channel and a change beyond the compared range, which separates compare-against-previous from compare-against-reset and shows the channel filter. Reads are issued alone, twice in a row, in the same clock as an event and at a foreign address, to tell clear-on-read, event retention and address decoding apart. Repeated and masked events then show that the interrupt fires once per read window and only for enabled bits.

// File: rtl/arx_irq_pkg.sv
package arx_irq_pkg;

   localparam int STAT_W = 8;
   localparam int LAT_N  = 4;   // latched event bits 7..4
   localparam int LVL_N  = 4;   // level bits 3..0

   localparam int B_TOP   = 7;  // mismatch / CRC channel 2
   localparam int B_CRC   = 6;  // CRC selected / CRC channel 1
   localparam int B_CHG   = 5;
   localparam int B_SLIP  = 4;
   localparam int B_ERR   = 3;

   typedef enum logic [1:0] {
      BM_SINGLE_A = 2'd0,
      BM_SINGLE_B = 2'd1,
      BM_DUAL     = 2'd2,
      BM_DUAL_ALT = 2'd3
   } buf_mode_e;

   function automatic logic mode_is_dual(input logic [1:0] m);
      return (buf_mode_e'(m) == BM_DUAL) || (buf_mode_e'(m) == BM_DUAL_ALT);
   endfunction

endpackage

// File: rtl/arx_crc_evt.sv
module arx_crc_evt (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dual,
   input  logic       ch_sel,
   input  logic       blk_end,
   input  logic       blk_viol,
   input  logic [1:0] crc_err,
   output logic       crc_lo_evt,
   output logic       crc_hi_evt
);

   logic sel_err;

   assign sel_err = ch_sel ? crc_err[1] : crc_err[0];

   always_comb begin
      crc_lo_evt = blk_viol;
      crc_hi_evt = 1'b0;
      if (dual) begin
         crc_hi_evt = blk_viol | (blk_end & crc_err[1]);
         crc_lo_evt = crc_lo_evt | (blk_end & crc_err[0]);
      end else begin
         crc_lo_evt = crc_lo_evt | (blk_end & sel_err);
      end
   end

   // R3: CRC flag only moves at a block boundary or violation
   p_crc_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_end && !blk_viol) |-> (!crc_lo_evt && !crc_hi_evt));

   // R4: channel-2 CRC event only in dual modes
   p_crc2_dual_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !dual |-> !crc_hi_evt);

endmodule

// File: rtl/arx_cs_track.sv
module arx_cs_track #(
   parameter int CS_BYTES = 4,
   parameter int IDX_W    = 5,
   parameter int BYTE_W   = 8,
   parameter int N_CH     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dual,
   input  logic              ch_sel,
   input  logic              cs_wr,
   input  logic              cs_ch,
   input  logic [IDX_W-1:0]  cs_idx,
   input  logic [BYTE_W-1:0] cs_byte,
   input  logic              pair_vld,
   input  logic [1:0]        pair_bits,
   output logic              cchg_evt,
   output logic              csdif_evt
);

   localparam int SLOTS = N_CH * CS_BYTES;

   logic [SLOTS-1:0] slot_diff;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      for (genvar b = 0; b < CS_BYTES; b++) begin : g_byte
         logic [BYTE_W-1:0] prev_q;
         logic              seen_q;
         logic              hit;
         logic              counts;

         assign hit    = cs_wr && (cs_ch == 1'(c)) && (cs_idx == IDX_W'(b));
         assign counts = dual || (ch_sel == 1'(c));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               prev_q <= '0;
               seen_q <= 1'b0;
            end else if (hit) begin
               prev_q <= cs_byte;
               seen_q <= 1'b1;
            end
         end

         assign slot_diff[c*CS_BYTES + b] = hit && counts && seen_q && (prev_q != cs_byte);
      end
   end

   assign cchg_evt  = |slot_diff;
   assign csdif_evt = !dual && pair_vld && (pair_bits[0] ^ pair_bits[1]);

   // R7: change detection needs a byte write
   p_cchg_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_wr |-> !cchg_evt);

   // R6: mismatch event never in dual modes
   p_csdif_dual_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dual |-> !csdif_evt);

endmodule

// File: rtl/arx_stat_core.sv
module arx_stat_core #(
   parameter int ADDR_W    = 4,
   parameter int STAT_ADDR = 0,
   parameter int LAT_N     = 4,
   parameter int LVL_N     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LAT_N-1:0]       lat_set,
   input  logic [LVL_N-1:0]       lvl_in,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic                   bus_wr,
   input  logic                   bus_rd,
   input  logic [LAT_N+LVL_N-1:0] bus_wdata,
   output logic [LAT_N+LVL_N-1:0] bus_rdata,
   output logic                   irq_n,
   output logic                   lvl_top
);

   localparam int W = LAT_N + LVL_N;

   logic [W-1:0]     en_q, seen_q, seen_eff, evt, fire, status, rdata_q;
   logic [LVL_N-1:0] lvl_q;
   logic             irq_n_q;
   logic             rd_hit, wr_hit;

   assign rd_hit   = bus_rd && (bus_addr == ADDR_W'(STAT_ADDR));
   assign wr_hit   = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));
   assign evt      = {lat_set, lvl_in & ~lvl_q};
   assign seen_eff = rd_hit ? '0 : seen_q;
   assign fire     = evt & en_q & ~seen_eff;
   assign status   = {seen_q[W-1:LVL_N], lvl_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= '0;
         seen_q  <= '0;
         lvl_q   <= '0;
         irq_n_q <= 1'b1;
         rdata_q <= '0;
      end else begin
         seen_q  <= seen_eff | evt;
         lvl_q   <= lvl_in;
         irq_n_q <= ~|fire;
         if (wr_hit) en_q <= bus_wdata;
         if (bus_rd) rdata_q <= rd_hit ? status : '0;
      end
   end

   assign bus_rdata = rdata_q;
   assign irq_n     = irq_n_q;
   assign lvl_top   = lvl_q[LVL_N-1];

   // R10: a read with no new event leaves the latched bits clear
   p_rd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && lat_set == '0) |=> (seen_q[W-1:LVL_N] == '0));

   // R12: an interrupt needs some enabled bit
   p_irq_enabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n_q |-> ($past(en_q) != '0));

   // R12: a pulse on a level bit needs a rise seen last cycle
   p_lvl_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n_q && $past(lat_set) == '0) |-> ($past(lvl_in & ~lvl_q) != '0));

endmodule

// File: rtl/audio_rx_irq_ctrl.sv
module audio_rx_irq_ctrl #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int STAT_ADDR = 0,
   parameter int CS_BYTES  = 4,
   parameter int CS_IDX_W  = 5,
   parameter int ERR_N     = 5,
   parameter int FLAG_N    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          buf_mode,
   input  logic                ch_sel,
   input  logic                slave_mode,
   input  logic                blk_end,
   input  logic                blk_viol,
   input  logic [1:0]          crc_err,
   input  logic                pair_vld,
   input  logic [1:0]          pair_bits,
   input  logic                cs_wr,
   input  logic                cs_ch,
   input  logic [CS_IDX_W-1:0] cs_idx,
   input  logic [7:0]          cs_byte,
   input  logic                slip_evt,
   input  logic [ERR_N-1:0]    err_src,
   input  logic [ERR_N-1:0]    err_en,
   input  logic [FLAG_N-1:0]   pos_flags,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq_n,
   output logic                err_flag
);

   import arx_irq_pkg::*;

   localparam int LVL_W = FLAG_N + 1;

   initial begin
      assert (DATA_W == STAT_W) else $error("status byte must be %0d bits", STAT_W);
      assert (LVL_W == LVL_N) else $error("flag count must give %0d level bits", LVL_N);
      assert (CS_BYTES >= 1 && CS_BYTES <= (1 << CS_IDX_W)) else $error("CS_BYTES out of range");
      assert (ERR_N >= 1) else $error("ERR_N must be positive");
   end

   logic             dual;
   logic             crc_lo, crc_hi, cchg, csdif, erf;
   logic [LAT_N-1:0] lat_set;
   logic [LVL_W-1:0] lvl_in;

   assign dual = mode_is_dual(buf_mode);
   assign erf  = |(err_src & err_en);

   arx_crc_evt u_crc (
      .clk(clk), .rst_n(rst_n), .dual(dual), .ch_sel(ch_sel),
      .blk_end(blk_end), .blk_viol(blk_viol), .crc_err(crc_err),
      .crc_lo_evt(crc_lo), .crc_hi_evt(crc_hi)
   );

   arx_cs_track #(.CS_BYTES(CS_BYTES), .IDX_W(CS_IDX_W), .BYTE_W(8), .N_CH(2)) u_cs (
      .clk(clk), .rst_n(rst_n), .dual(dual), .ch_sel(ch_sel),
      .cs_wr(cs_wr), .cs_ch(cs_ch), .cs_idx(cs_idx), .cs_byte(cs_byte),
      .pair_vld(pair_vld), .pair_bits(pair_bits),
      .cchg_evt(cchg), .csdif_evt(csdif)
   );

   assign lat_set = {crc_hi | csdif, crc_lo, cchg, slip_evt & slave_mode};
   assign lvl_in  = {erf, pos_flags};

   arx_stat_core #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .LAT_N(LAT_N), .LVL_N(LVL_W)) u_core (
      .clk(clk), .rst_n(rst_n), .lat_set(lat_set), .lvl_in(lvl_in),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_n(irq_n), .lvl_top(err_flag)
   );

   // R9: error flag follows the enabled sources one clock later
   p_err_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag == $past(erf));

   // R8: slip never latched while the serial port is master
   p_slip_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && slip_evt && !bus_rd && !u_core.seen_q[B_SLIP]) |=> !u_core.seen_q[B_SLIP]);

endmodule

// File: tb/audio_rx_irq_ctrl_bench.sv
`timescale 1ns/1ps
module audio_rx_irq_ctrl_bench;

   logic       clk = 0, rst_n = 0;
   logic [1:0] buf_mode = 0;
   logic       ch_sel = 0, slave_mode = 0, blk_end = 0, blk_viol = 0;
   logic [1:0] crc_err = 0;
   logic       pair_vld = 0;
   logic [1:0] pair_bits = 0;
   logic       cs_wr = 0, cs_ch = 0;
   logic [4:0] cs_idx = 0;
   logic [7:0] cs_byte = 0;
   logic       slip_evt = 0;
   logic [4:0] err_src = 0, err_en = 0;
   logic [2:0] pos_flags = 0;
   logic [3:0] bus_addr = 0;
   logic       bus_wr = 0, bus_rd = 0;
   logic [7:0] bus_wdata = 0;
   logic [7:0] bus_rdata;
   logic       irq_n, err_flag;

   int tests = 0, fails = 0;
   bit cmp_on = 0, done = 0;

   always #4 clk = ~clk;

   audio_rx_irq_ctrl u_audio_rx_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode), .ch_sel(ch_sel),
      .slave_mode(slave_mode), .blk_end(blk_end), .blk_viol(blk_viol),
      .crc_err(crc_err), .pair_vld(pair_vld), .pair_bits(pair_bits),
      .cs_wr(cs_wr), .cs_ch(cs_ch), .cs_idx(cs_idx), .cs_byte(cs_byte),
      .slip_evt(slip_evt), .err_src(err_src), .err_en(err_en),
      .pos_flags(pos_flags), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_n(irq_n), .err_flag(err_flag)
   );

   // behavioural reference
   int  m_seen[8];
   int  m_lvl[4];
   int  m_en[8];
   int  m_mem[2][4];
   int  m_have[2][4];
   int  m_rdata, m_irq, m_erf;

   always @(posedge clk) begin
      int ev[8];
      int nl[4];
      int isdual, rh, st, anyfire;
      if (!rst_n) begin
         foreach (m_seen[i]) begin m_seen[i] = 0; m_en[i] = 0; end
         foreach (m_lvl[i]) m_lvl[i] = 0;
         foreach (m_have[c, b]) begin m_have[c][b] = 0; m_mem[c][b] = 0; end
         m_rdata = 0; m_irq = 1; m_erf = 0;
      end else begin
         isdual = (buf_mode >= 2) ? 1 : 0;
         foreach (ev[i]) ev[i] = 0;
         if (blk_end) begin
            if (isdual != 0) begin
               if (crc_err[0]) ev[6] = 1;
               if (crc_err[1]) ev[7] = 1;
            end else if (crc_err[ch_sel]) ev[6] = 1;
         end
         if (blk_viol) begin ev[6] = 1; if (isdual != 0) ev[7] = 1; end
         if (isdual == 0 && pair_vld && pair_bits[0] != pair_bits[1]) ev[7] = 1;
         if (cs_wr && cs_idx < 4) begin
            if ((isdual != 0 || cs_ch == ch_sel) && m_have[cs_ch][cs_idx] != 0
                && m_mem[cs_ch][cs_idx] != int'(cs_byte)) ev[5] = 1;
            m_mem[cs_ch][cs_idx] = int'(cs_byte);
            m_have[cs_ch][cs_idx] = 1;
         end
         if (slip_evt && slave_mode) ev[4] = 1;
         nl[3] = ((err_src & err_en) != 0) ? 1 : 0;
         nl[2] = int'(pos_flags[2]); nl[1] = int'(pos_flags[1]); nl[0] = int'(pos_flags[0]);
         for (int i = 0; i < 4; i++) if (nl[i] != 0 && m_lvl[i] == 0) ev[i] = 1;
         rh = (bus_rd && bus_addr == 0) ? 1 : 0;
         st = 0;
         for (int i = 4; i < 8; i++) st += m_seen[i] << i;
         for (int i = 0; i < 4; i++) st += m_lvl[i] << i;
         if (bus_rd) m_rdata = (rh != 0) ? st : 0;
         anyfire = 0;
         for (int i = 0; i < 8; i++) begin
            if (rh != 0) m_seen[i] = 0;
            if (ev[i] != 0 && m_en[i] != 0 && m_seen[i] == 0) anyfire = 1;
            if (ev[i] != 0) m_seen[i] = 1;
         end
         m_irq = (anyfire != 0) ? 0 : 1;
         for (int i = 0; i < 4; i++) m_lvl[i] = nl[i];
         m_erf = nl[3];
         if (bus_wr && bus_addr == 0) for (int i = 0; i < 8; i++) m_en[i] = int'(bus_wdata[i]);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) if (cmp_on) begin
      check("R12 irq_n vs model", int'(irq_n), m_irq);
      check("R9 err_flag vs model", int'(err_flag), m_erf);
      check("R10 rdata vs model", int'(bus_rdata), m_rdata);
   end

   task automatic tick(); @(negedge clk); endtask

   task automatic rd(input logic [3:0] a, input int exp, input string req);
      bus_addr = a; bus_rd = 1; tick(); bus_rd = 0; bus_addr = 0;
      check(req, int'(bus_rdata), exp);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1; tick(); bus_wr = 0; bus_addr = 0;
   endtask

   task automatic blk(input logic [1:0] e);
      crc_err = e; blk_end = 1; tick(); blk_end = 0; crc_err = 0;
   endtask

   task automatic viol(); blk_viol = 1; tick(); blk_viol = 0; endtask

   task automatic pair(input logic [1:0] p);
      pair_bits = p; pair_vld = 1; tick(); pair_vld = 0;
   endtask

   task automatic csw(input logic c, input logic [4:0] i, input logic [7:0] d);
      cs_ch = c; cs_idx = i; cs_byte = d; cs_wr = 1; tick(); cs_wr = 0;
   endtask

   task automatic slip(); slip_evt = 1; tick(); slip_evt = 0; endtask

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      cmp_on = 1;
      check("R1 irq_n after reset", int'(irq_n), 1);
      check("R1 err_flag after reset", int'(err_flag), 0);
      rd(0, 8'h00, "R1 status after reset");

      wr(0, 8'hFF);
      pos_flags = 3'b101; tick();
      check("R12 irq on flag rise", int'(irq_n), 0);
      rd(0, 8'h05, "R2 flag bits");
      pos_flags = 0; tick();

      buf_mode = 0; ch_sel = 1;
      blk(2'b01);            rd(0, 8'h00, "R3 unselected crc ignored");
      blk(2'b10);            rd(0, 8'h40, "R3 selected crc sets bit6");
      crc_err = 2'b11; tick(); crc_err = 0;
      rd(0, 8'h00, "R3 crc without block end ignored");

      buf_mode = 2;
      blk(2'b10);            rd(0, 8'h80, "R4 dual crc2 bit7");
      blk(2'b01);            rd(0, 8'h40, "R4 dual crc1 bit6");

      buf_mode = 1; viol(); rd(0, 8'h40, "R5 violation single");
      buf_mode = 2; viol(); rd(0, 8'hC0, "R5 violation dual");

      buf_mode = 0;
      pair(2'b01);           rd(0, 8'h80, "R6 mismatch sets bit7");
      pair(2'b11);           rd(0, 8'h00, "R6 equal pair no effect");
      buf_mode = 2;
      pair(2'b01);           rd(0, 8'h00, "R6 dual ignores pair");

      buf_mode = 0; ch_sel = 0;
      csw(0, 0, 8'h11);      rd(0, 8'h00, "R7 first write no change");
      csw(0, 0, 8'h11);      rd(0, 8'h00, "R7 equal rewrite");
      csw(0, 0, 8'h12);      rd(0, 8'h20, "R7 changed byte");
      csw(1, 0, 8'h33); csw(1, 0, 8'h34);
      rd(0, 8'h00, "R7 unselected channel ignored");
      buf_mode = 2;
      csw(1, 0, 8'h35);      rd(0, 8'h20, "R7 dual counts both channels");
      csw(0, 5, 8'h01); csw(0, 5, 8'h02);
      rd(0, 8'h00, "R7 index beyond range ignored");

      slave_mode = 0; slip(); rd(0, 8'h00, "R8 slip ignored as master");
      slave_mode = 1; slip(); rd(0, 8'h10, "R8 slip in slave mode");

      err_src = 5'b00100; err_en = 0; tick();
      check("R9 masked source", int'(err_flag), 0);
      err_en = 5'b00100; tick();
      check("R9 enabled source", int'(err_flag), 1);
      rd(0, 8'h08, "R9 error bit3");
      rd(0, 8'h08, "R10 level bit not cleared");
      err_src = 0; err_en = 0; tick();

      slip(); rd(0, 8'h10, "R10 read returns slip");
      rd(0, 8'h00, "R10 read cleared latched");
      slip_evt = 1; bus_addr = 0; bus_rd = 1; tick(); slip_evt = 0; bus_rd = 0;
      check("R10 same-cycle read returns old", int'(bus_rdata), 8'h00);
      rd(0, 8'h10, "R10 same-cycle event kept");

      wr(1, 8'h00);
      slip();
      check("R11 foreign write ignored, irq fires", int'(irq_n), 0);
      rd(1, 8'h00, "R11 foreign read returns zero");
      rd(0, 8'h10, "R11 foreign read did not clear");

      slip(); slip();
      check("R12 repeat gives no irq", int'(irq_n), 1);
      rd(0, 8'h10, "R12 status after repeats");
      slip();
      check("R12 irq rearmed after read", int'(irq_n), 0);
      rd(0, 8'h10, "R12 clear before mask test");
      wr(0, 8'hEF);
      slip();
      check("R12 masked bit no irq", int'(irq_n), 1);
      rd(0, 8'h10, "R12 masked event still latched");

      tick(); tick();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule